// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five prioritised localities (numbered 0 to 4) owns a shared command interface. Each locality has a byte-wide access register, reached through a write or read port tagged with a locality number. Software requests ownership, gives it up or seizes it through action bits in that byte. The arbiter keeps a request flag, a seize flag and a seized-from flag for each locality, and reports the current owner on dedicated outputs.

Some hand-overs would interrupt a command that the current owner has started: a release with other localities waiting, or a seize by a higher locality. In these cases the arbiter asserts an abort request toward the command engine and changes the owner only after the engine answers with an abort-complete pulse. Every real change of owner produces a one-cycle change event for the interrupt logic. Locality 4 is reserved for hardware. Its register accepts writes only when a separate hardware strobe accompanies them.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality is active, `abort_req` and `loc_changed` are low, and every valid locality reads its access byte as 0x80 with bit 0 equal to `est_in`.
- R2: A read returns the addressed access byte in `rd_data` one cycle after `rd_en`. Bit 7 reads 1 and bit 6 reads 0. Bit 5 is 1 when this locality is the owner, bit 4 is its seized-from flag and bit 3 always reads 0. Bit 2 is 1 when any other locality holds a request. Bit 1 is its own request flag and bit 0 is `est_in`. A locality number of 5 or above reads 0x00.
- R3: A write with bit 1 (request) set while no locality is active makes the writer the owner on the next cycle, with `loc_changed` pulsed.
- R4: A request from a non-owner while another locality is active only sets the writer's request flag. The owner is unchanged.
- R5: When the owner writes bit 5 (release) and no locality holds a request, the owner becomes none on the next cycle and `loc_changed` is pulsed.
- R6: When the owner releases while requests exist, the new owner is the highest-numbered requester. `abort_req` rises on the next cycle and stays high until `abort_done`. The hand-over happens on the cycle after `abort_done`, and the old owner loses both its active status and its request.
- R7: A non-owner that writes bit 5 clears its own request flag.
- R8: A write with bit 3 (seize) is accepted only when no locality is active or the writer outranks the owner. It is refused when the writer already has a seize pending or when a higher locality has one. An accepted seize clears the seize flags of lower localities. With no owner, it grants ownership at once; otherwise it goes through the abort hand-over of R6.
- R9: On a seize hand-over the old owner's seized-from flag (bit 4) is set and its request flag is kept. The new owner's request and seize flags are cleared.
- R10: Writing 1 to bit 4 clears the writer's seized-from flag. A write with bit 3 set ignores bits 1 and 5 of the same byte.
- R11: Writes to locality 4 are discarded unless `hw_access` is high in the same cycle.
- R12: `loc_changed` pulses exactly when the owner differs from the previous cycle. When `abort_done` and a write fall in the same cycle, the pending hand-over is applied first and the write is then evaluated against the new owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Access-register write strobe |
| rd_en | input | 1 | Access-register read strobe |
| hw_access | input | 1 | Hardware qualifier that allows writes to locality 4 |
| loc_sel | input | LOC_W | Locality addressed by the read or write |
| wr_data | input | 8 | Write byte (action bits) |
| est_in | input | 1 | Establishment status reflected in read bit 0 |
| abort_done | input | 1 | Command engine has finished the requested abort |
| rd_data | output | 8 | Access byte of the last read |
| active_valid | output | 1 | A locality currently owns the interface |
| active_loc | output | LOC_W | Owning locality (0 when none) |
| loc_changed | output | 1 | One-cycle pulse on every change of owner |
| abort_req | output | 1 | Hand-over waiting for the running command to be aborted |

## Verification
The two functions that can fall in one cycle are completing a deferred hand-over and processing a new register write. The bench starts a hand-over from locality 4 to locality 2. It then pulses `abort_done` in the same cycle that locality 2 writes its release bit. If the hand-over is applied first, locality 2 is the owner by the time its release is evaluated, so the interface ends with no owner and a change pulse. If the write were evaluated first, it would only clear a request flag and locality 2 would remain the owner, so the final owner tells the two orders apart.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    localparam int DEF_NUM_LOC = 5;
    localparam int DEF_HW_LOC  = 4;

    // access byte bit positions
    localparam int B_REGVALID = 7;
    localparam int B_ACTIVE   = 5;
    localparam int B_SEIZED   = 4;
    localparam int B_SEIZE    = 3;
    localparam int B_PENDING  = 2;
    localparam int B_REQUEST  = 1;
    localparam int B_ESTAB    = 0;

    typedef struct packed {
        logic release_own;
        logic clear_seized;
        logic seize;
        logic request;
    } act_bits_t;

    // a seize in the same byte masks request and release
    function automatic act_bits_t decode_actions(logic rel_b, logic bs_b,
                                                 logic sz_b, logic rq_b);
        act_bits_t a;
        a.seize        = sz_b;
        a.clear_seized = bs_b;
        a.release_own  = rel_b & ~sz_b;
        a.request      = rq_b & ~sz_b;
        return a;
    endfunction

    function automatic logic [7:0] access_byte(logic act, logic seized,
                                               logic pend, logic req,
                                               logic est);
        logic [7:0] r;
        r             = '0;
        r[B_REGVALID] = 1'b1;
        r[B_ACTIVE]   = act;
        r[B_SEIZED]   = seized;
        r[B_PENDING]  = pend;
        r[B_REQUEST]  = req;
        r[B_ESTAB]    = est;
        return r;
    endfunction

endpackage

// File: rtl/loc_wr_decode.sv
module loc_wr_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = DEF_NUM_LOC,
    parameter int HW_LOC  = DEF_HW_LOC,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic             wr_en,
    input  logic             hw_access,
    input  logic [LOC_W-1:0] loc_sel,
    input  logic [7:0]       wr_data,
    output logic             cmd_vld,
    output act_bits_t        cmd_act
);
    logic in_range;
    logic hw_ok;
    logic unused_bits;

    assign in_range    = (int'(loc_sel) < NUM_LOC);
    assign hw_ok       = (int'(loc_sel) != HW_LOC) || hw_access;
    assign cmd_vld     = wr_en && in_range && hw_ok;
    assign cmd_act     = decode_actions(wr_data[B_ACTIVE], wr_data[B_SEIZED],
                                        wr_data[B_SEIZE], wr_data[B_REQUEST]);
    assign unused_bits = ^{wr_data[7:6], wr_data[B_PENDING], wr_data[B_ESTAB]};
endmodule

// File: rtl/loc_arb_core.sv
module loc_arb_core
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = DEF_NUM_LOC,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_vld,
    input  act_bits_t          cmd_act,
    input  logic [LOC_W-1:0]   cmd_loc,
    input  logic               abort_done,
    output logic               own_v,
    output logic [LOC_W-1:0]   own_id,
    output logic               pend_v,
    output logic               changed,
    output logic [NUM_LOC-1:0] req_flags,
    output logic [NUM_LOC-1:0] seized_flags
);
    typedef struct packed {
        logic [NUM_LOC-1:0] rq;
        logic [NUM_LOC-1:0] sz;
        logic [NUM_LOC-1:0] bs;
        logic               ov;
        logic [LOC_W-1:0]   oid;
        logic               chg;
    } arb_st_t;

    arb_st_t          cur_q, nxt;
    logic             pv_q, pv_n;
    logic [LOC_W-1:0] pid_q, pid_n;

    // move ownership to (tv, tid); tv=0 means no owner
    function automatic arb_st_t hand_over(arb_st_t s, logic tv, logic [LOC_W-1:0] tid);
        arb_st_t r;
        logic    moved;
        logic    by_seize;
        r        = s;
        moved    = (s.ov != tv) || (s.ov && tv && (s.oid != tid));
        by_seize = tv && s.sz[tid];
        if (moved && s.ov) begin
            if (by_seize) r.bs[s.oid] = 1'b1;
            else          r.rq[s.oid] = 1'b0;
        end
        r.ov  = tv;
        r.oid = tv ? tid : '0;
        if (tv) begin
            r.rq[tid] = 1'b0;
            r.sz[tid] = 1'b0;
        end
        if (moved) r.chg = 1'b1;
        return r;
    endfunction

    always_comb begin
        arb_st_t          s;
        logic             apply;
        logic             tv;
        logic [LOC_W-1:0] tid;
        logic             found;
        logic [LOC_W-1:0] fid;
        logic             higher_sz;
        logic             is_owner;

        s     = cur_q;
        s.chg = 1'b0;
        pv_n  = pv_q;
        pid_n = pid_q;

        // stage 1: finish a deferred hand-over
        if (abort_done && pv_q) begin
            s     = hand_over(s, 1'b1, pid_q);
            pv_n  = 1'b0;
            pid_n = '0;
        end

        // stage 2: register write, seen against stage-1 result
        apply     = 1'b0;
        tv        = s.ov;
        tid       = s.oid;
        found     = 1'b0;
        fid       = '0;
        higher_sz = 1'b0;
        is_owner  = s.ov && (s.oid == cmd_loc);
        if (cmd_vld) begin
            apply = 1'b1;
            if (cmd_act.release_own) begin
                if (is_owner) begin
                    for (int i = NUM_LOC - 1; i >= 0; i--) begin
                        if (!found && s.rq[i]) begin
                            found = 1'b1;
                            fid   = LOC_W'(i);
                        end
                    end
                    if (found) begin
                        pv_n  = 1'b1;
                        pid_n = fid;
                        apply = 1'b0;
                    end else begin
                        tv  = 1'b0;
                        tid = '0;
                    end
                end else begin
                    s.rq[cmd_loc] = 1'b0;
                end
            end
            if (cmd_act.clear_seized) s.bs[cmd_loc] = 1'b0;
            if (cmd_act.seize) begin
                for (int i = 0; i < NUM_LOC; i++) begin
                    if (i > int'(cmd_loc) && s.sz[i]) higher_sz = 1'b1;
                end
                if ((!s.ov || cmd_loc > s.oid) && !s.sz[cmd_loc] && !higher_sz) begin
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (i < int'(cmd_loc)) s.sz[i] = 1'b0;
                    end
                    s.sz[cmd_loc] = 1'b1;
                    if (s.ov) begin
                        pv_n  = 1'b1;
                        pid_n = cmd_loc;
                        apply = 1'b0;
                    end else begin
                        tv  = 1'b1;
                        tid = cmd_loc;
                    end
                end
            end
            if (cmd_act.request && !is_owner) begin
                if (s.ov) s.rq[cmd_loc] = 1'b1;
                else begin
                    tv  = 1'b1;
                    tid = cmd_loc;
                end
            end
        end
        if (apply) s = hand_over(s, tv, tid);
        nxt = s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            pv_q  <= 1'b0;
            pid_q <= '0;
        end else begin
            cur_q <= nxt;
            pv_q  <= pv_n;
            pid_q <= pid_n;
        end
    end

    assign own_v        = cur_q.ov;
    assign own_id       = cur_q.oid;
    assign pend_v       = pv_q;
    assign changed      = cur_q.chg;
    assign req_flags    = cur_q.rq;
    assign seized_flags = cur_q.bs;
endmodule

// File: rtl/loc_rd_mux.sv
module loc_rd_mux
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = DEF_NUM_LOC,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [LOC_W-1:0]   loc_sel,
    input  logic               own_v,
    input  logic [LOC_W-1:0]   own_id,
    input  logic [NUM_LOC-1:0] req_flags,
    input  logic [NUM_LOC-1:0] seized_flags,
    input  logic               est_in,
    output logic [7:0]         rd_data
);
    logic [NUM_LOC-1:0] others;
    logic [7:0]         byte_n;

    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) begin
            others[i] = (i != int'(loc_sel));
        end
        if (int'(loc_sel) < NUM_LOC)
            byte_n = access_byte(own_v && (own_id == loc_sel),
                                 seized_flags[loc_sel],
                                 |(req_flags & others),
                                 req_flags[loc_sel], est_in);
        else
            byte_n = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= 8'h00;
        else if (rd_en) rd_data <= byte_n;
    end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = DEF_NUM_LOC,
    parameter int HW_LOC  = DEF_HW_LOC,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             hw_access,
    input  logic [LOC_W-1:0] loc_sel,
    input  logic [7:0]       wr_data,
    input  logic             est_in,
    input  logic             abort_done,
    output logic [7:0]       rd_data,
    output logic             active_valid,
    output logic [LOC_W-1:0] active_loc,
    output logic             loc_changed,
    output logic             abort_req
);
    logic               cmd_vld;
    act_bits_t          cmd_act;
    logic [NUM_LOC-1:0] req_flags;
    logic [NUM_LOC-1:0] seized_flags;

    loc_wr_decode #(.NUM_LOC(NUM_LOC), .HW_LOC(HW_LOC), .LOC_W(LOC_W)) u_dec (
        .wr_en    (wr_en),
        .hw_access(hw_access),
        .loc_sel  (loc_sel),
        .wr_data  (wr_data),
        .cmd_vld  (cmd_vld),
        .cmd_act  (cmd_act)
    );

    loc_arb_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .cmd_vld     (cmd_vld),
        .cmd_act     (cmd_act),
        .cmd_loc     (loc_sel),
        .abort_done  (abort_done),
        .own_v       (active_valid),
        .own_id      (active_loc),
        .pend_v      (abort_req),
        .changed     (loc_changed),
        .req_flags   (req_flags),
        .seized_flags(seized_flags)
    );

    loc_rd_mux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .loc_sel     (loc_sel),
        .own_v       (active_valid),
        .own_id      (active_loc),
        .req_flags   (req_flags),
        .seized_flags(seized_flags),
        .est_in      (est_in),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/loc_arb_checker.sv
module loc_arb_checker #(
    parameter int NUM_LOC = 5,
    parameter int HW_LOC  = 4,
    parameter int LOC_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             hw_access,
    input logic [LOC_W-1:0] loc_sel,
    input logic [7:0]       wr_data,
    input logic             abort_done,
    input logic [7:0]       rd_data,
    input logic             active_valid,
    input logic [LOC_W-1:0] active_loc,
    input logic             loc_changed,
    input logic             abort_req
);
    p_event_means_move_r12: assert property (@(posedge clk) disable iff (rst)
        loc_changed |-> ({active_valid, active_loc} != $past({active_valid, active_loc})));

    p_quiet_means_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !loc_changed |-> $stable({active_valid, active_loc}));

    p_abort_held_r6: assert property (@(posedge clk) disable iff (rst)
        (abort_req && !abort_done) |=> abort_req);

    p_abort_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (abort_req && abort_done && !wr_en) |=> !abort_req);

    p_hw_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(loc_sel) == HW_LOC && !hw_access && !abort_req)
        |=> $stable({active_valid, active_loc}));

    p_read_owner_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && active_valid && loc_sel == active_loc) |=> rd_data[5]);

    p_idle_grab_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !abort_req && !active_valid && int'(loc_sel) < NUM_LOC &&
         (int'(loc_sel) != HW_LOC || hw_access) && wr_data[1] && !wr_data[3])
        |=> (active_valid && active_loc == $past(loc_sel)));
endmodule

bind loc_arbiter loc_arb_checker #(.NUM_LOC(NUM_LOC), .HW_LOC(HW_LOC), .LOC_W(LOC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .hw_access   (hw_access),
    .loc_sel     (loc_sel),
    .wr_data     (wr_data),
    .abort_done  (abort_done),
    .rd_data     (rd_data),
    .active_valid(active_valid),
    .active_loc  (active_loc),
    .loc_changed (loc_changed),
    .abort_req   (abort_req)
);

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, hw_access = 1'b0;
    logic [2:0] loc_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       est_in = 1'b0, abort_done = 1'b0;
    logic [7:0] rd_data;
    logic       active_valid, loc_changed, abort_req;
    logic [2:0] active_loc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    loc_arbiter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .hw_access(hw_access),
        .loc_sel(loc_sel), .wr_data(wr_data), .est_in(est_in), .abort_done(abort_done),
        .rd_data(rd_data), .active_valid(active_valid), .active_loc(active_loc),
        .loc_changed(loc_changed), .abort_req(abort_req)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic owner_is(string req, logic v, logic [2:0] id, logic chg, logic ab);
        check(req, {4'd0, active_valid, active_loc}, {4'd0, v, id});
        check(req, {6'd0, loc_changed, abort_req}, {6'd0, chg, ab});
    endtask

    task automatic wr(logic [2:0] l, logic [7:0] d, logic hw);
        @(negedge clk);
        wr_en = 1'b1; loc_sel = l; wr_data = d; hw_access = hw;
        @(negedge clk);
        wr_en = 1'b0; hw_access = 1'b0;
    endtask

    task automatic rd(logic [2:0] l, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; loc_sel = l;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        owner_is("R1", 1'b0, 3'd0, 1'b0, 1'b0);
        rd(3'd0, v); check("R1", v, 8'h80);
        est_in = 1'b1;
        rd(3'd2, v); check("R1", v, 8'h81);
        rd(3'd5, v); check("R2", v, 8'h00);
    endtask

    task automatic t_request();
        logic [7:0] v;
        wr(3'd1, 8'h02, 1'b0); owner_is("R3", 1'b1, 3'd1, 1'b1, 1'b0);
        rd(3'd1, v); check("R2", v, 8'hA1);
        wr(3'd2, 8'h02, 1'b0); owner_is("R4", 1'b1, 3'd1, 1'b0, 1'b0);
        rd(3'd2, v); check("R4", v, 8'h83);
        rd(3'd1, v); check("R2", v, 8'hA5);
        rd(3'd0, v); check("R2", v, 8'h85);
    endtask

    task automatic t_nonowner_release();
        logic [7:0] v;
        wr(3'd3, 8'h02, 1'b0);
        wr(3'd3, 8'h20, 1'b0);
        rd(3'd3, v); check("R7", v, 8'h85);
    endtask

    task automatic t_handover();
        logic [7:0] v;
        wr(3'd3, 8'h02, 1'b0);
        wr(3'd1, 8'h20, 1'b0); owner_is("R6", 1'b1, 3'd1, 1'b0, 1'b1);
        @(negedge clk);       owner_is("R6", 1'b1, 3'd1, 1'b0, 1'b1);
        done_pulse();         owner_is("R6", 1'b1, 3'd3, 1'b1, 1'b0);
        rd(3'd1, v); check("R6", v, 8'h85);
        rd(3'd3, v); check("R6", v, 8'hA5);
    endtask

    task automatic t_seize();
        logic [7:0] v;
        wr(3'd2, 8'h08, 1'b0); owner_is("R8", 1'b1, 3'd3, 1'b0, 1'b0);
        wr(3'd4, 8'h08, 1'b1); owner_is("R8", 1'b1, 3'd3, 1'b0, 1'b1);
        done_pulse();          owner_is("R9", 1'b1, 3'd4, 1'b1, 1'b0);
        rd(3'd3, v); check("R9", v, 8'h95);
        rd(3'd4, v); check("R9", v, 8'hA5);
        wr(3'd3, 8'h10, 1'b0);
        rd(3'd3, v); check("R10", v, 8'h85);
    endtask

    task automatic t_hw_gate();
        wr(3'd4, 8'h20, 1'b0); owner_is("R11", 1'b1, 3'd4, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle();
        wr(3'd4, 8'h20, 1'b1); owner_is("R6", 1'b1, 3'd4, 1'b0, 1'b1);
        @(negedge clk);
        abort_done = 1'b1; wr_en = 1'b1; loc_sel = 3'd2; wr_data = 8'h20;
        @(negedge clk);
        abort_done = 1'b0; wr_en = 1'b0;
        owner_is("R12", 1'b0, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        owner_is("R5", 1'b0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_seize_idle_and_refuse();
        logic [7:0] v;
        wr(3'd1, 8'h0A, 1'b0); owner_is("R8", 1'b1, 3'd1, 1'b1, 1'b0);
        rd(3'd1, v); check("R10", v, 8'hA1);
        wr(3'd3, 8'h08, 1'b0); owner_is("R8", 1'b1, 3'd1, 1'b0, 1'b1);
        wr(3'd2, 8'h08, 1'b0);
        done_pulse();          owner_is("R8", 1'b1, 3'd3, 1'b1, 1'b0);
        rd(3'd1, v); check("R9", v, 8'h91);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_request();
        t_nonowner_release();
        t_handover();
        t_seize();
        t_hw_gate();
        t_same_cycle();
        t_seize_idle_and_refuse();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule